// File: doc/BRIEF.md
# Speculative ECC Read Return Path

This block sits between a cache data array and the unit that requested a line. Read beats arrive from the array one per cycle, each with a 64-bit data word and an 8-bit SECDED code. In the default mode a beat is passed to the requestor in the same cycle it arrives, while a two-stage decoder checks it in parallel. The short hit latency is paid for with a recovery step. If the decoder later flags a beat, a one-cycle kill pulse voids what was sent in the two preceding cycles. The output then switches to the checked stream, which starts with the corrected copy of the flagged beat.

A configuration input turns speculative forwarding off. Every beat then leaves through the checked stream, exactly two cycles later, and a single-bit error never shows at the requestor as a kill. An uncorrectable beat raises a flag and is never delivered, and neither is the rest of its line. A saturating counter reports how many single-bit corrections have been made.

Top module: `spec_ecc_return`

## Requirements
- R1: With `fwd_dis_i` low and no error being recovered, every beat with `raw_valid_i` high appears in the same cycle on `out_valid_o`/`out_data_o` unchanged, with its beat index on `out_idx_o`.
- R2: In speculative mode, a beat that arrives in cycle t with an error makes `out_kill_o` pulse for one cycle in cycle t+2. The pulse voids the beats delivered in cycles t and t+1. Beats delivered before cycle t are not voided.
- R3: When that error is correctable, the corrected flagged beat is delivered with its index in the kill cycle. The following beats are then delivered corrected, in arrival order, each two cycles after arrival. No raw beat is forwarded until the check pipeline is empty, and after that the block forwards speculatively again.
- R4: With `fwd_dis_i` high, each beat is delivered checked and corrected exactly two cycles after it arrives.
- R5: With `fwd_dis_i` high, a single-bit error never raises `out_kill_o`.
- R6: The code is an extended Hamming (72,64) code. Data bit i sits at the i-th codeword position, counting upward from 3, that is not a power of two. `raw_ecc_i[j]` for j in 0..6 is the XOR of the data bits whose position has bit j set. `raw_ecc_i[7]` is the XOR of all 64 data bits and `raw_ecc_i[6:0]`. Any single flipped bit among the 72, check bits included, is corrected.
- R7: A beat with two flipped bits pulses `ue_o` in its checked cycle, t+2. It is not delivered, and no later beat of the same line is delivered. In speculative mode it also raises the R2 kill.
- R8: Beat indices run 0 to BEATS-1 in arrival order and wrap at each line boundary.
- R9: `sec_cnt_o` counts corrected single-bit errors in both modes and holds at its all-ones value.
- R10: During reset, `out_valid_o`, `out_kill_o` and `ue_o` are low and `sec_cnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwd_dis_i | input | 1 | High: deliver only checked data |
| raw_valid_i | input | 1 | A beat from the array is present |
| raw_data_i | input | 64 | Beat data as read from the array |
| raw_ecc_i | input | 8 | SECDED check bits of the beat |
| out_valid_o | output | 1 | Beat delivered to the requestor |
| out_data_o | output | 64 | Delivered beat data |
| out_idx_o | output | IDX_W | Beat index within its line |
| out_kill_o | output | 1 | Voids beats delivered in the previous two cycles |
| ue_o | output | 1 | Uncorrectable error in the checked beat |
| sec_cnt_o | output | CNT_W | Corrected single-bit error count |

## Verification
The assertions assume that `fwd_dis_i` changes only while no beat is in flight. The latency and kill properties read its past values and rely on it being stable across the window. The stimulus changes the mode only between lines, after at least six idle cycles. Lines are always sent as BEATS consecutive beats, so beat indices stay aligned with line boundaries. No beat ever has more than two flipped bits.

// File: rtl/ecc_ret_pkg.sv
package ecc_ret_pkg;
  localparam int unsigned DW = 64;
  localparam int unsigned CW = 8;
  localparam int unsigned PW = CW - 1;
  localparam logic [PW-1:0] MAX_POS = PW'(DW + PW);

  // codeword position of data bit i (non power of two positions, ascending)
  function automatic logic [PW-1:0] data_pos(input int unsigned i);
    int unsigned n;
    logic [PW-1:0] r;
    n = 0;
    r = '0;
    for (int unsigned p = 3; p < (1 << PW); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == i) r = PW'(p);
        n++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_ret_dec.sv
module ecc_ret_dec
  import ecc_ret_pkg::*;
(
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] ecc_i,
  output logic [DW-1:0] data_o,
  output logic          sec_o,
  output logic          ded_o
);
  logic [PW-1:0] syn;
  logic          par;

  always_comb begin
    syn = ecc_i[PW-1:0];
    for (int i = 0; i < DW; i++)
      if (data_i[i]) syn ^= data_pos(i);
  end

  assign par   = ^{data_i, ecc_i};
  assign sec_o = par & (syn <= MAX_POS);
  assign ded_o = (~par & (syn != '0)) | (par & (syn > MAX_POS));

  always_comb begin
    for (int i = 0; i < DW; i++)
      data_o[i] = data_i[i] ^ (sec_o && (syn == data_pos(i)));
  end

  always_comb begin
    p_sec_ded_excl_r6: assert (!(sec_o && ded_o));
  end
endmodule

// File: rtl/ecc_ret_cnt.sv
module ecc_ret_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (inc_i && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_sat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1) |=> (cnt_q == '1));
  p_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/spec_ecc_return.sv
module spec_ecc_return
  import ecc_ret_pkg::*;
#(
  parameter int unsigned BEATS = 4,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fwd_dis_i,
  input  logic             raw_valid_i,
  input  logic [DW-1:0]    raw_data_i,
  input  logic [CW-1:0]    raw_ecc_i,
  output logic             out_valid_o,
  output logic [DW-1:0]    out_data_o,
  output logic [IDX_W-1:0] out_idx_o,
  output logic             out_kill_o,
  output logic             ue_o,
  output logic [CNT_W-1:0] sec_cnt_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic [IDX_W-1:0] in_idx_q;
  logic             s1_v_q, s2_v_q;
  logic [DW-1:0]    s1_data_q, s2_data_q;
  logic [CW-1:0]    s1_ecc_q;
  logic [IDX_W-1:0] s1_idx_q, s2_idx_q;
  logic             s2_sec_q, s2_ded_q;
  logic [DW-1:0]    dec_data;
  logic             dec_sec, dec_ded;
  logic             chk_q, drop_q;
  logic             err_spec, use_chk, chk_ok, s2_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          in_idx_q <= '0;
    else if (raw_valid_i) in_idx_q <= (in_idx_q == LAST_IDX) ? '0 : in_idx_q + 1'b1;
  end

  // stage 1: raw capture, stage 2: decoded result (check ready 2 cycles after arrival)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q    <= 1'b0;
      s1_data_q <= '0;
      s1_ecc_q  <= '0;
      s1_idx_q  <= '0;
      s2_v_q    <= 1'b0;
      s2_data_q <= '0;
      s2_idx_q  <= '0;
      s2_sec_q  <= 1'b0;
      s2_ded_q  <= 1'b0;
    end else begin
      s1_v_q    <= raw_valid_i;
      s1_data_q <= raw_data_i;
      s1_ecc_q  <= raw_ecc_i;
      s1_idx_q  <= in_idx_q;
      s2_v_q    <= s1_v_q;
      s2_data_q <= dec_data;
      s2_idx_q  <= s1_idx_q;
      s2_sec_q  <= s1_v_q & dec_sec;
      s2_ded_q  <= s1_v_q & dec_ded;
    end
  end

  ecc_ret_dec u_dec (
    .data_i (s1_data_q),
    .ecc_i  (s1_ecc_q),
    .data_o (dec_data),
    .sec_o  (dec_sec),
    .ded_o  (dec_ded)
  );

  assign s2_last  = s2_idx_q == LAST_IDX;
  assign err_spec = s2_v_q & (s2_sec_q | s2_ded_q) & ~fwd_dis_i & ~chk_q;
  assign use_chk  = fwd_dis_i | chk_q | err_spec;
  assign chk_ok   = s2_v_q & ~s2_ded_q & ~drop_q;

  // stay on the checked stream until the pipeline drains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_q <= 1'b0;
    else         chk_q <= (chk_q | err_spec) & (raw_valid_i | s1_v_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   drop_q <= 1'b0;
    else if (s2_v_q && s2_last)    drop_q <= 1'b0;
    else if (s2_v_q && s2_ded_q)   drop_q <= 1'b1;
  end

  assign out_valid_o = use_chk ? chk_ok    : raw_valid_i;
  assign out_data_o  = use_chk ? s2_data_q : raw_data_i;
  assign out_idx_o   = use_chk ? s2_idx_q  : in_idx_q;
  assign out_kill_o  = err_spec;
  assign ue_o        = s2_v_q & s2_ded_q;

  ecc_ret_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (s2_v_q & s2_sec_q),
    .cnt_o  (sec_cnt_o)
  );

  p_kill_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_kill_o && $past(!fwd_dis_i, 2)) |-> $past(out_valid_o, 2));
  p_chk_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_dis_i && $past(fwd_dis_i) && $past(fwd_dis_i, 2) && out_valid_o)
      |-> $past(raw_valid_i, 2));
  p_no_kill_dis_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_dis_i && $past(fwd_dis_i)) |-> !out_kill_o);
  p_ue_not_sent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_o |-> !out_valid_o);
  p_idx_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idx_q <= LAST_IDX) && (s2_idx_q <= LAST_IDX));
endmodule

// File: tb/spec_ecc_return_tb.sv
module spec_ecc_return_tb;
  localparam int BEATS = 4;
  localparam int CNT_W = 4;
  localparam int NC    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd_dis = 1'b0;
  logic raw_valid = 1'b0;
  logic [63:0] raw_data = '0;
  logic [7:0]  raw_ecc = '0;
  logic        out_valid, out_kill, ue;
  logic [63:0] out_data;
  logic [1:0]  out_idx;
  logic [CNT_W-1:0] sec_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int fa [BEATS];
  int fb [BEATS];
  logic        cv [NC];
  logic        ck [NC];
  logic        cu [NC];
  logic [1:0]  ci [NC];
  logic [63:0] cd [NC];

  always #5 clk = ~clk;

  spec_ecc_return #(.BEATS(BEATS), .CNT_W(CNT_W)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .fwd_dis_i (fwd_dis),
    .raw_valid_i (raw_valid), .raw_data_i (raw_data), .raw_ecc_i (raw_ecc),
    .out_valid_o (out_valid), .out_data_o (out_data), .out_idx_o (out_idx),
    .out_kill_o (out_kill), .ue_o (ue), .sec_cnt_o (sec_cnt)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d exp=<20000 cycles", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [6:0] pos_of(input int i);
    int p = 2, n = -1;
    while (n < i) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return 7'(p);
  endfunction

  function automatic logic [7:0] enc(input logic [63:0] d);
    logic [6:0] e = '0;
    for (int i = 0; i < 64; i++) if (d[i]) e ^= pos_of(i);
    return {^d ^ ^e, e};
  endfunction

  function automatic logic [63:0] beat(input int seed, input int b);
    return {32'(seed) * 32'h9E37_79B9 ^ 32'hC0DE_0000, 32'(b) * 32'h1111_2223 ^ 32'(seed)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_flips();
    for (int b = 0; b < BEATS; b++) begin fa[b] = -1; fb[b] = -1; end
  endtask

  task automatic run_line(input int seed);
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      if (c < BEATS) begin
        logic [71:0] cw;
        cw = {enc(beat(seed, c)), beat(seed, c)};
        if (fa[c] >= 0) cw[fa[c]] = ~cw[fa[c]];
        if (fb[c] >= 0) cw[fb[c]] = ~cw[fb[c]];
        raw_valid = 1'b1;
        raw_data  = cw[63:0];
        raw_ecc   = cw[71:64];
      end else begin
        raw_valid = 1'b0;
      end
      #2;
      cv[c] = out_valid; ck[c] = out_kill; cu[c] = ue;
      ci[c] = out_idx;   cd[c] = out_data;
    end
  endtask

  task automatic t_reset();
    chk("R10 valid in reset", 64'(out_valid), 64'd0);
    chk("R10 kill in reset", 64'(out_kill), 64'd0);
    chk("R10 ue in reset", 64'(ue), 64'd0);
    chk("R10 count in reset", 64'(sec_cnt), 64'd0);
  endtask

  task automatic t_clean_spec(input int seed);
    clear_flips();
    run_line(seed);
    for (int c = 0; c < BEATS; c++) begin
      chk("R1 same-cycle valid", 64'(cv[c]), 64'd1);
      chk("R1 same-cycle data", cd[c], beat(seed, c));
      chk("R8 index", 64'(ci[c]), 64'(c));
    end
    for (int c = 0; c < NC; c++) chk("R2 no kill clean", 64'(ck[c]), 64'd0);
    chk("R1 idle after line", 64'(cv[BEATS]), 64'd0);
  endtask

  task automatic t_sec_spec(input int seed);
    clear_flips();
    fa[1] = 17;
    run_line(seed);
    chk("R1 beat0", cd[0], beat(seed, 0));
    chk("R1 raw beat1 forwarded", cd[1], beat(seed, 1) ^ (64'd1 << 17));
    chk("R1 beat2 raw", 64'(cv[2]), 64'd1);
    chk("R2 no early kill", 64'({ck[0], ck[1], ck[2]}), 64'd0);
    chk("R2 kill at t+2", 64'(ck[3]), 64'd1);
    chk("R2 single pulse", 64'(ck[4]), 64'd0);
    chk("R3 corrected idx in kill cycle", 64'(ci[3]), 64'd1);
    chk("R3 corrected data", cd[3], beat(seed, 1));
    chk("R3 valid in kill cycle", 64'(cv[3]), 64'd1);
    chk("R3 replay idx2", 64'(ci[4]), 64'd2);
    chk("R3 replay data2", cd[4], beat(seed, 2));
    chk("R3 replay idx3", 64'(ci[5]), 64'd3);
    chk("R3 replay data3", cd[5], beat(seed, 3));
    chk("R3 no extra beat", 64'(cv[6]), 64'd0);
    chk("R9 count after one SEC", 64'(sec_cnt), 64'd1);
  endtask

  task automatic t_ded_spec(input int seed);
    clear_flips();
    fa[2] = 5; fb[2] = 9;
    run_line(seed);
    chk("R7 beats before flag sent", 64'({cv[0], cv[1], cv[2], cv[3]}), 64'hF);
    chk("R7 kill", 64'(ck[4]), 64'd1);
    chk("R7 ue", 64'(cu[4]), 64'd1);
    chk("R7 bad beat not sent", 64'(cv[4]), 64'd0);
    chk("R7 rest of line dropped", 64'(cv[5]), 64'd0);
    chk("R7 single ue", 64'(cu[5]), 64'd0);
    chk("R9 DED not counted", 64'(sec_cnt), 64'd1);
  endtask

  task automatic t_dis(input int seed);
    clear_flips();
    fa[0] = 64 + 7; fa[1] = 64; fa[2] = 63; fa[3] = 0;
    run_line(seed);
    chk("R4 nothing at t", 64'({cv[0], cv[1]}), 64'd0);
    for (int b = 0; b < BEATS; b++) begin
      chk("R4 valid at t+2", 64'(cv[b + 2]), 64'd1);
      chk("R6 corrected data", cd[b + 2], beat(seed, b));
      chk("R8 index checked path", 64'(ci[b + 2]), 64'(b));
    end
    for (int c = 0; c < NC; c++) chk("R5 no kill when disabled", 64'(ck[c]), 64'd0);
    chk("R9 count after four SEC", 64'(sec_cnt), 64'd5);
  endtask

  task automatic t_sat();
    for (int l = 0; l < 3; l++) begin
      clear_flips();
      for (int b = 0; b < BEATS; b++) fa[b] = 3 * b + l;
      run_line(40 + l);
    end
    chk("R9 saturated", 64'(sec_cnt), 64'd15);
  endtask

  initial begin
    clear_flips();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_clean_spec(1);
    t_sec_spec(2);
    t_clean_spec(3);
    t_ded_spec(4);
    t_clean_spec(5);
    fwd_dis = 1'b1;
    repeat (2) @(negedge clk);
    t_dis(6);
    t_sat();
    fwd_dis = 1'b0;
    repeat (2) @(negedge clk);
    t_clean_spec(7);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule